// File: doc/BRIEF.md
# Four-Channel Ring Position Counter with Index Output

The block holds four 28-bit up/down position counters. Each counter picks its count pulse and its direction from a shared bank of event sources, using its own 4-bit source code. Counters one and two can each be placed in ring mode. In ring mode the count stays between zero and a compare value, and it wraps at both ends. Each counter has a one-cycle capture strobe that copies the count into a capture register. An optional per-counter bit clears the count at that same edge.

The fourth counter drives an index output, which has two behaviours. In level behaviour, the output is high while counter four equals compare value two. In pulse behaviour, a down-count of counter four that lands on zero produces a pulse exactly two clocks wide. Pulse behaviour needs two conditions: the pulse-mode bit is set and counter four's source code is 8, 9 or 10. A small write port sets the configuration and the two compare values. A combinational read port returns these registers and the four capture registers.

Each counter applies one action per clock. The actions are HOLD, UP, DOWN, WRAP_LO (compare value to 0), WRAP_HI (0 to compare value) and CLEAR.

The index machine has three states: IDX_IDLE, IDX_HI1 and IDX_HI2. The transitions are:
- IDLE->HI1 on a down-count to zero.
- HI1->HI2 and HI2->IDLE when no new event arrives.
- HI1->HI1 and HI2->HI1 when a new event restarts the pulse.
- Any state to IDLE when pulse behaviour is not in force.

Top module: `pcnt_top`

## Requirements
- R1: After reset, all counters, capture registers, configuration and compare registers read 0. The index output is high, because counter four (0) equals compare two (0).
- R2: Source code c in 1..12 makes a counter step when src_step[c-1] is high, upward if src_up[c-1] is 1 and downward otherwise. Codes 0 and 13..15 hold the counter whatever the sources do.
- R3: Outside ring mode a counter moves by exactly one per step, in 28-bit two's complement, so counting down from 0 gives 0x0FFFFFFE after two steps.
- R4: With ring mode on, counter one (bounded by compare one) or counter two (bounded by compare two) steps up from its compare value to 0.
- R5: With ring mode on, counter one or counter two steps down from 0 to its compare value.
- R6: A capture strobe on counter n copies the count held before that edge into the capture register, which reads at address 4+n (n = 0..3).
- R7: When a counter's clear-on-capture bit is set, a strobe clears the count at the same edge. The clear beats a step in that cycle, and the captured value is the pre-clear count.
- R8: With the clear-on-capture bit off, a strobe leaves the count unchanged.
- R9: In level behaviour the index output is high exactly while counter four equals compare two, one clock after the step that makes them equal.
- R10: In pulse behaviour (configuration bit 22 set, counter four code 8, 9 or 10), a down step of counter four to 0 raises the index for exactly the two clocks after that edge. A match with compare two has no effect.
- R11: A new down step to zero while the pulse is high restarts the two-clock pulse.
- R12: With bit 22 set but counter four code outside 8..10, the index keeps level behaviour and a down step to zero gives no pulse.
- R13: The register map is as follows. Address 0 holds the configuration: bits [4n+3:4n] are counter n's code, bits 17:16 are ring enables for counters one and two, bits 21:18 are the clear-on-capture bits, and bit 22 selects pulse behaviour. Address 1 holds compare one and address 2 holds compare two. Writes take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_step | input | 12 | Count pulse per event source |
| src_up | input | 12 | Direction per event source, 1 = up |
| cap_stb | input | 4 | Capture strobe per counter |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| index_o | output | 1 | Index output |

## Verification
Each counter and each capture register moves at the edge that samples its step or strobe, so both are due one clock after the stimulus. The bench drives on the falling edge and reads at the next falling edge. Level-behaviour index follows the registered count and is checked in that same half-cycle. The pulse is checked at three falling edges in a row after the zero-reaching step: high, high, low. The restart case is checked over five falling edges. Register writes are checked through the read port one clock after the write.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
    localparam int SEL_W  = 4;
    localparam int N_CNT  = 4;
    localparam int N_RING = 2;

    localparam logic [SEL_W-1:0] PULSE_SEL_A = 4'd8;
    localparam logic [SEL_W-1:0] PULSE_SEL_B = 4'd9;
    localparam logic [SEL_W-1:0] PULSE_SEL_C = 4'd10;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_UP,
        ACT_DOWN,
        ACT_WRAP_LO,
        ACT_WRAP_HI,
        ACT_CLEAR
    } cnt_act_e;

    typedef enum logic [1:0] {
        IDX_IDLE,
        IDX_HI1,
        IDX_HI2
    } idx_state_e;

    typedef struct packed {
        logic                         pulse_mode;
        logic [N_CNT-1:0]             clr_on_cap;
        logic [N_RING-1:0]            ring_on;
        logic [N_CNT-1:0][SEL_W-1:0]  sel;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/pcnt_src_sel.sv
module pcnt_src_sel
    import pcnt_pkg::*;
#(
    parameter int N_SRC = 12
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic [N_SRC-1:0] src_step_i,
    input  logic [N_SRC-1:0] src_up_i,
    output logic             step_o,
    output logic             up_o
);
    always_comb begin
        step_o = 1'b0;
        up_o   = 1'b0;
        for (int s = 0; s < N_SRC; s++) begin
            if (sel_i == SEL_W'(s + 1)) begin
                step_o = src_step_i[s];
                up_o   = src_up_i[s];
            end
        end
    end
endmodule

// File: rtl/pcnt_cnt.sv
module pcnt_cnt
    import pcnt_pkg::*;
#(
    parameter int CW      = 28,
    parameter bit RING_OK = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          up_i,
    input  logic          ring_i,
    input  logic [CW-1:0] bound_i,
    input  logic          cap_i,
    input  logic          clr_on_cap_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cap_o,
    output logic          dn_zero_o
);
    localparam logic [CW-1:0] ZERO = '0;
    localparam logic [CW-1:0] ONE  = CW'(1);

    cnt_act_e      act;
    logic [CW-1:0] cnt_q, cnt_d, cap_q;
    logic          ring_live;

    assign ring_live = RING_OK && ring_i;

    always_comb begin
        if (cap_i && clr_on_cap_i) begin
            act = ACT_CLEAR;
        end else if (!step_i) begin
            act = ACT_HOLD;
        end else if (up_i) begin
            act = (ring_live && cnt_q == bound_i) ? ACT_WRAP_LO : ACT_UP;
        end else begin
            act = (ring_live && cnt_q == ZERO) ? ACT_WRAP_HI : ACT_DOWN;
        end
    end

    always_comb begin
        unique case (act)
            ACT_HOLD:    cnt_d = cnt_q;
            ACT_UP:      cnt_d = cnt_q + ONE;
            ACT_DOWN:    cnt_d = cnt_q - ONE;
            ACT_WRAP_LO: cnt_d = ZERO;
            ACT_WRAP_HI: cnt_d = bound_i;
            ACT_CLEAR:   cnt_d = ZERO;
            default:     cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
            cap_q <= ZERO;
        end else begin
            cnt_q <= cnt_d;
            if (cap_i) begin
                cap_q <= cnt_q;
            end
        end
    end

    assign dn_zero_o = (act == ACT_DOWN) && (cnt_q == ONE);
    assign cnt_o     = cnt_q;
    assign cap_o     = cap_q;
endmodule

// File: rtl/pcnt_index.sv
module pcnt_index
    import pcnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_mode_i,
    input  logic dn_zero_i,
    input  logic match_i,
    output logic index_o
);
    idx_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IDX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!pulse_mode_i) begin
            state_d = IDX_IDLE;
        end else begin
            unique case (state_q)
                IDX_IDLE: state_d = dn_zero_i ? IDX_HI1 : IDX_IDLE;
                IDX_HI1:  state_d = dn_zero_i ? IDX_HI1 : IDX_HI2;
                IDX_HI2:  state_d = dn_zero_i ? IDX_HI1 : IDX_IDLE;
                default:  state_d = IDX_IDLE;
            endcase
        end
    end

    always_comb begin
        if (pulse_mode_i) begin
            index_o = (state_q != IDX_IDLE);
        end else begin
            index_o = match_i;
        end
    end
endmodule

// File: rtl/pcnt_regs.sv
module pcnt_regs
    import pcnt_pkg::*;
#(
    parameter int CW = 28,
    parameter int DW = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [2:0]                wr_addr,
    input  logic [DW-1:0]             wr_data,
    input  logic [2:0]                rd_addr,
    input  logic [N_CNT-1:0][CW-1:0]  cap_i,
    output logic [DW-1:0]             rd_data,
    output cfg_t                      cfg_o,
    output logic [CW-1:0]             cmp1_o,
    output logic [CW-1:0]             cmp2_o
);
    localparam int PAD_C = DW - CW;
    localparam int PAD_G = DW - CFG_W;

    localparam logic [2:0] A_CFG  = 3'd0;
    localparam logic [2:0] A_CMP1 = 3'd1;
    localparam logic [2:0] A_CMP2 = 3'd2;

    cfg_t          cfg_q;
    logic [CW-1:0] cmp1_q, cmp2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            cmp1_q <= '0;
            cmp2_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CFG:   cfg_q  <= cfg_t'(wr_data[CFG_W-1:0]);
                A_CMP1:  cmp1_q <= wr_data[CW-1:0];
                A_CMP2:  cmp2_q <= wr_data[CW-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (rd_addr)
            3'd0:    rd_data = {{PAD_G{1'b0}}, cfg_q};
            3'd1:    rd_data = {{PAD_C{1'b0}}, cmp1_q};
            3'd2:    rd_data = {{PAD_C{1'b0}}, cmp2_q};
            3'd4:    rd_data = {{PAD_C{1'b0}}, cap_i[0]};
            3'd5:    rd_data = {{PAD_C{1'b0}}, cap_i[1]};
            3'd6:    rd_data = {{PAD_C{1'b0}}, cap_i[2]};
            3'd7:    rd_data = {{PAD_C{1'b0}}, cap_i[3]};
            default: rd_data = '0;
        endcase
    end

    assign cfg_o  = cfg_q;
    assign cmp1_o = cmp1_q;
    assign cmp2_o = cmp2_q;
endmodule

// File: rtl/pcnt_top.sv
module pcnt_top
    import pcnt_pkg::*;
#(
    parameter int N_SRC = 12,
    parameter int CW    = 28,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_step,
    input  logic [N_SRC-1:0] src_up,
    input  logic [3:0]       cap_stb,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [2:0]       rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic             index_o
);
    cfg_t                      cfg;
    logic [CW-1:0]             cmp1, cmp2;
    logic [N_CNT-1:0][CW-1:0]  cnt, cap, bound;
    logic [N_CNT-1:0]          step, up, ring, dz;
    logic                      pulse_mode, match4;

    pcnt_regs #(.CW(CW), .DW(DW)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .cap_i   (cap),
        .rd_data (rd_data),
        .cfg_o   (cfg),
        .cmp1_o  (cmp1),
        .cmp2_o  (cmp2)
    );

    for (genvar k = 0; k < N_CNT; k++) begin : g_ch
        localparam bit HAS_RING = (k < N_RING);

        if (HAS_RING) begin : g_ring
            assign ring[k]  = cfg.ring_on[k];
            assign bound[k] = (k == 0) ? cmp1 : cmp2;
        end else begin : g_flat
            assign ring[k]  = 1'b0;
            assign bound[k] = '0;
        end

        pcnt_src_sel #(.N_SRC(N_SRC)) sel_i (
            .sel_i      (cfg.sel[k]),
            .src_step_i (src_step),
            .src_up_i   (src_up),
            .step_o     (step[k]),
            .up_o       (up[k])
        );

        pcnt_cnt #(.CW(CW), .RING_OK(HAS_RING)) cnt_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .step_i       (step[k]),
            .up_i         (up[k]),
            .ring_i       (ring[k]),
            .bound_i      (bound[k]),
            .cap_i        (cap_stb[k]),
            .clr_on_cap_i (cfg.clr_on_cap[k]),
            .cnt_o        (cnt[k]),
            .cap_o        (cap[k]),
            .dn_zero_o    (dz[k])
        );
    end

    assign pulse_mode = cfg.pulse_mode &&
                        (cfg.sel[3] == PULSE_SEL_A ||
                         cfg.sel[3] == PULSE_SEL_B ||
                         cfg.sel[3] == PULSE_SEL_C);
    assign match4 = (cnt[3] == cmp2);

    pcnt_index idx_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pulse_mode_i (pulse_mode),
        .dn_zero_i    (dz[3]),
        .match_i      (match4),
        .index_o      (index_o)
    );
endmodule

// File: rtl/pcnt_chk.sv
module pcnt_chk
    import pcnt_pkg::*;
#(
    parameter int CW = 28
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [3:0]                cap_stb,
    input logic [N_CNT-1:0][CW-1:0]  cnt,
    input logic [N_CNT-1:0][CW-1:0]  cap,
    input logic [N_CNT-1:0][CW-1:0]  bound,
    input logic [N_CNT-1:0]          step,
    input logic [N_CNT-1:0]          up,
    input logic [N_CNT-1:0]          ring,
    input logic [N_CNT-1:0]          dz,
    input logic [N_CNT-1:0]          clr_bits,
    input logic                      pulse_mode,
    input logic                      index_o
);
    for (genvar k = 0; k < N_CNT; k++) begin : g_a
        AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
            cap_stb[k] |=> cap[k] == $past(cnt[k])); // R6

        AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            cap_stb[k] && clr_bits[k] |=> cnt[k] == '0); // R7

        AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !step[k] && !cap_stb[k] |=> $stable(cnt[k])); // R2

        AST_RING_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
            ring[k] && step[k] && up[k] && cnt[k] == bound[k] &&
            !(cap_stb[k] && clr_bits[k]) |=> cnt[k] == '0); // R4

        AST_RING_WRAP_DN: assert property (@(posedge clk) disable iff (!rst_n)
            ring[k] && step[k] && !up[k] && cnt[k] == '0 &&
            !(cap_stb[k] && clr_bits[k]) |=> cnt[k] == $past(bound[k])); // R5
    end

    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_mode && dz[3] |=> (index_o || !pulse_mode)); // R10

    AST_PULSE_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(index_o) && pulse_mode && $past(pulse_mode) |=> (index_o || !pulse_mode)); // R10
endmodule

bind pcnt_top pcnt_chk #(.CW(CW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_stb    (cap_stb),
    .cnt        (cnt),
    .cap        (cap),
    .bound      (bound),
    .step       (step),
    .up         (up),
    .ring       (ring),
    .dz         (dz),
    .clr_bits   (cfg.clr_on_cap),
    .pulse_mode (pulse_mode),
    .index_o    (index_o)
);

// File: tb/pcnt_top_tb_top.sv
module pcnt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] src_step = '0;
    logic [11:0] src_up = '0;
    logic [3:0]  cap_stb = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        index_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    pcnt_top dut_i (
        .clk(clk), .rst_n(rst_n), .src_step(src_step), .src_up(src_up),
        .cap_stb(cap_stb), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .index_o(index_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] cfg(input logic [3:0] s1, input logic [3:0] s2,
                                        input logic [3:0] s4, input logic [1:0] rg,
                                        input logic [3:0] clr, input logic pm);
        return {9'd0, pm, clr, rg, s4, 4'd0, s2, s1};
    endfunction

    task automatic steps(input int src, input bit dir_up, input int n);
        for (int i = 0; i < n; i++) begin
            src_step[src] = 1'b1; src_up[src] = dir_up;
            @(negedge clk);
        end
        src_step = '0;
    endtask

    task automatic capture(input logic [3:0] m);
        cap_stb = m;
        @(negedge clk);
        cap_stb = '0;
    endtask

    task automatic read_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) read_chk("R1 reg", 3'(a), 32'd0);
        check("R1 index", {31'd0, index_o}, 32'd1);
    endtask

    task automatic t_count();
        wr(3'd0, cfg(4'd1, 4'd0, 4'd0, 2'b00, 4'b0000, 1'b0));
        read_chk("R13 cfg readback", 3'd0, cfg(4'd1, 4'd0, 4'd0, 2'b00, 4'b0000, 1'b0));
        steps(0, 1'b1, 5);
        capture(4'b0001);
        read_chk("R2 up five", 3'd4, 32'd5);
        steps(0, 1'b0, 7);
        capture(4'b0001);
        read_chk("R3 below zero", 3'd4, 32'h0FFF_FFFE);
    endtask

    task automatic t_ignore();
        wr(3'd0, cfg(4'd13, 4'd0, 4'd0, 2'b00, 4'b0000, 1'b0));
        src_step = '1; src_up = '1;
        @(negedge clk); @(negedge clk);
        src_step = '0;
        capture(4'b0001);
        read_chk("R2 code 13 holds", 3'd4, 32'h0FFF_FFFE);
        wr(3'd0, cfg(4'd0, 4'd0, 4'd0, 2'b00, 4'b0000, 1'b0));
        src_step = '1;
        @(negedge clk);
        src_step = '0;
        capture(4'b0001);
        read_chk("R2 code 0 holds", 3'd4, 32'h0FFF_FFFE);
    endtask

    task automatic t_ring1();
        wr(3'd0, cfg(4'd1, 4'd0, 4'd0, 2'b01, 4'b0001, 1'b0));
        capture(4'b0001);
        wr(3'd1, 32'd3);
        read_chk("R13 cmp1", 3'd1, 32'd3);
        steps(0, 1'b1, 6);
        capture(4'b0001);
        read_chk("R4 ring up wrap", 3'd4, 32'd2);
        steps(0, 1'b0, 1);
        capture(4'b0001);
        read_chk("R5 ring down wrap", 3'd4, 32'd3);
    endtask

    task automatic t_clear();
        steps(0, 1'b1, 2);
        src_step[0] = 1'b1; src_up[0] = 1'b1; cap_stb = 4'b0001;
        @(negedge clk);
        src_step = '0; cap_stb = '0;
        read_chk("R7 pre-clear captured", 3'd4, 32'd2);
        capture(4'b0001);
        read_chk("R7 clear beats step", 3'd4, 32'd0);
        wr(3'd0, cfg(4'd1, 4'd0, 4'd0, 2'b01, 4'b0000, 1'b0));
        steps(0, 1'b1, 1);
        capture(4'b0001);
        capture(4'b0001);
        read_chk("R8 no clear", 3'd4, 32'd1);
        steps(0, 1'b1, 1);
        capture(4'b0001);
        read_chk("R8 count kept", 3'd4, 32'd2);
    endtask

    task automatic t_ring2();
        wr(3'd0, cfg(4'd1, 4'd2, 4'd0, 2'b10, 4'b0000, 1'b0));
        wr(3'd2, 32'd2);
        steps(1, 1'b0, 1);
        capture(4'b0010);
        read_chk("R5 ring2 down wrap", 3'd5, 32'd2);
        steps(1, 1'b1, 1);
        capture(4'b0010);
        read_chk("R4 ring2 up wrap", 3'd5, 32'd0);
    endtask

    task automatic t_level();
        wr(3'd0, cfg(4'd0, 4'd0, 4'd8, 2'b00, 4'b0000, 1'b0));
        check("R9 no match", {31'd0, index_o}, 32'd0);
        steps(7, 1'b1, 1);
        check("R9 at 1", {31'd0, index_o}, 32'd0);
        steps(7, 1'b1, 1);
        check("R9 at cmp", {31'd0, index_o}, 32'd1);
        steps(7, 1'b1, 1);
        check("R9 past cmp", {31'd0, index_o}, 32'd0);
    endtask

    task automatic t_pulse();
        wr(3'd0, cfg(4'd0, 4'd0, 4'd8, 2'b00, 4'b0000, 1'b1));
        steps(7, 1'b0, 1);
        check("R10 match ignored", {31'd0, index_o}, 32'd0);
        steps(7, 1'b0, 1);
        check("R10 at 1", {31'd0, index_o}, 32'd0);
        steps(7, 1'b0, 1);
        check("R10 first", {31'd0, index_o}, 32'd1);
        @(negedge clk);
        check("R10 second", {31'd0, index_o}, 32'd1);
        @(negedge clk);
        check("R10 ended", {31'd0, index_o}, 32'd0);
    endtask

    task automatic t_restart();
        steps(7, 1'b1, 1);
        check("R11 idle", {31'd0, index_o}, 32'd0);
        steps(7, 1'b0, 1);
        check("R11 c0", {31'd0, index_o}, 32'd1);
        steps(7, 1'b1, 1);
        check("R11 c1", {31'd0, index_o}, 32'd1);
        steps(7, 1'b0, 1);
        check("R11 c2", {31'd0, index_o}, 32'd1);
        @(negedge clk);
        check("R11 c3", {31'd0, index_o}, 32'd1);
        @(negedge clk);
        check("R11 c4", {31'd0, index_o}, 32'd0);
    endtask

    task automatic t_other_sel();
        wr(3'd0, cfg(4'd0, 4'd0, 4'd5, 2'b00, 4'b0000, 1'b1));
        steps(4, 1'b1, 2);
        check("R12 level kept", {31'd0, index_o}, 32'd1);
        steps(4, 1'b0, 2);
        check("R12 no pulse", {31'd0, index_o}, 32'd0);
        @(negedge clk);
        check("R12 still low", {31'd0, index_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_ignore();
        t_ring1();
        t_clear();
        t_ring2();
        t_level();
        t_pulse();
        t_restart();
        t_other_sel();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule